// File: doc/BRIEF.md
# Debug Address and Value Match Unit

This unit sits beside a processor pipeline and watches two streams every cycle: the instruction fetch address and the data access (address, direction, data). It holds a bank of instruction slots and a bank of data slots. Each slot compares addresses in one of four ways: exact, inside a range, outside a range, or under a bit mask. Each data slot is paired with its own value comparator. That comparator can require the access data to match a programmed 64-bit value under a set of byte enables. A hit vector with one bit per slot and a combined debug-event pulse come out one cycle after the matching fetch or access.

Slots are not written by index. A request port carries one complete event description. A small allocator checks the description, picks the lowest free slot of the needed kind and loads the address comparator and its paired value comparator in the same clock edge. One cycle later it returns a handle, a no-space flag or a bad-configuration flag. Handing the handle back on the release port frees the slot. An elaboration option makes the unit reject data watchpoints that are not 8-byte aligned.

Top module: `dbg_match_unit`

## Requirements
- R1: With the default sizes, handles 0 to 3 are instruction slots and handles 4 and 5 are data slots. An accepted request takes the lowest-numbered free slot of its kind. The response (rspValid with the handle) appears in the cycle after the request.
- R2: If no slot of the requested kind is free, the response has rspNoSpace=1 and no slot changes.
- R3: A release frees the slot named by relHandle. A release of a free or out-of-range handle has no effect. A release and a request in the same cycle are handled release first, so the request can take the slot just freed.
- R4: Address mode 0 (exact) hits when the address equals the first programmed address.
- R5: Address mode 1 (inclusive range) hits when first <= address <= second, compared unsigned. It never hits when first > second.
- R6: Address mode 2 (exclusive range) hits when the address is below the first or above the second. It always hits when first > second.
- R7: Address mode 3 (mask) hits when (address & second) == (first & second).
- R8: Trigger bits: execute is bit 0 (value 1), read is bit 1 (value 2), write is bit 2 (value 4). A data slot hits only for the directions it enables. A data request with neither read nor write set, an instruction request without execute set, or a condition word with any bit set outside bits 1:0 and 23:16 gets rspBadCfg=1 and is not loaded.
- R9: Condition word bits 1:0 select the value mode: 0 is none, 1 is AND, 2 is OR, 3 is AND-OR. Bit 16+i enables data byte i (data bits 8i+7:8i). Mode 0 ignores the data. In AND mode every enabled byte must equal the programmed value byte. An empty enable set counts as a match.
- R10: In OR mode one matching enabled byte is enough. In AND-OR mode, bytes 0-3 and bytes 4-7 are two AND groups and the slot hits if either group has at least one enabled byte and all of that group's enabled bytes match. An empty enable set still counts as a match.
- R11: hitVec shows, one cycle after the fetch or access, every slot that matched in that cycle. Instruction and data hits can be set together. debugEvent is high in that same cycle if any hitVec bit is set. Both outputs last one cycle per matching fetch or access.
- R12: Reset leaves every slot free, disabled and not hitting. When globalEn is low, no slot hits.
- R13: With ALIGN8=1, a data request is rejected with rspBadCfg if its first address is not a multiple of 8. An inclusive-range data request is also rejected if its second address is below the first or more than 8 above it. With ALIGN8=0 these requests are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| globalEn | input | 1 | Master enable for all hits |
| reqValid | input | 1 | Event request strobe |
| reqData | input | 1 | 1 requests a data slot, 0 an instruction slot |
| reqTrig | input | 3 | Trigger bits: execute, read, write |
| reqAddrMode | input | 2 | Address match mode |
| reqCond | input | 32 | Condition word: value mode and byte enables |
| reqAddrA | input | ADDR_W | First address |
| reqAddrB | input | ADDR_W | Second address or mask |
| reqValue | input | DATA_W | Condition value |
| relValid | input | 1 | Release strobe |
| relHandle | input | HANDLE_W | Handle to free |
| rspValid | output | 1 | Response to the previous cycle's request |
| rspHandle | output | HANDLE_W | Slot handle granted |
| rspNoSpace | output | 1 | No free slot of the needed kind |
| rspBadCfg | output | 1 | Request description rejected |
| fetchValid | input | 1 | Fetch address valid |
| fetchAddr | input | ADDR_W | Fetch address |
| accValid | input | 1 | Data access valid |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| accAddr | input | ADDR_W | Data access address |
| accData | input | DATA_W | Data access value |
| hitVec | output | NUM_INST+NUM_DATA | Registered hit bit for each slot |
| debugEvent | output | 1 | Registered OR of all hits |

## Verification
Two pairs of functions can fall in the same cycle. A release and a new request can meet: the bench fills all instruction slots, then releases one handle in the same cycle it asks for a new instruction slot, and expects the freed handle back with no no-space flag. A fetch and a data access can also both hit: the bench drives them together and expects both hit bits and a single debugEvent one cycle later, with hitVec still clear before the clock edge and clear again one cycle after.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  typedef enum logic [1:0] {
    AM_EXACT     = 2'd0,
    AM_IN_RANGE  = 2'd1,
    AM_OUT_RANGE = 2'd2,
    AM_MASK      = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    VC_NONE   = 2'd0,
    VC_ALL    = 2'd1,
    VC_ANY    = 2'd2,
    VC_HALVES = 2'd3
  } valMode_e;

  localparam int TRIG_EXEC  = 0;
  localparam int TRIG_READ  = 1;
  localparam int TRIG_WRITE = 2;
  localparam int COND_W     = 32;
  localparam int VMODE_W    = 2;
  localparam int BE_LSB     = 16;
  localparam int SLOT_IW    = 4;

  // load strobe from the allocator to the comparator bank
  typedef struct packed {
    logic               load;
    logic [SLOT_IW-1:0] slot;
  } cfgStrobe_t;

endpackage

// File: rtl/dbg_match_ctrl.sv
module dbg_match_ctrl
  import dbg_match_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int NUM_DATA = 2,
  parameter int ADDR_W   = 32,
  parameter int NB       = 8,
  parameter bit ALIGN8   = 1'b0,
  localparam int NSLOT   = NUM_INST + NUM_DATA,
  localparam int HW      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqData,
  input  logic [2:0]        reqTrig,
  input  logic [1:0]        reqAddrMode,
  input  logic [COND_W-1:0] reqCond,
  input  logic [ADDR_W-1:0] reqAddrA,
  input  logic [ADDR_W-1:0] reqAddrB,
  input  logic              relValid,
  input  logic [HW-1:0]     relHandle,
  output cfgStrobe_t        strobe,
  output logic [NSLOT-1:0]  slotActive,
  output logic              rspValid,
  output logic [HW-1:0]     rspHandle,
  output logic              rspNoSpace,
  output logic              rspBadCfg
);

  localparam logic [HW:0] NSLOT_V = NSLOT[HW:0];

  logic [NSLOT-1:0]  busy, relHot, freeVec, kindMask, candVec, pickHot;
  logic [HW-1:0]     pickIdx;
  logic              pickFound, trigBad, rsvdBad, alignBad, cfgBad, accept;
  logic [ADDR_W-1:0] span;

  always_comb begin
    relHot = '0;
    if (relValid && ({1'b0, relHandle} < NSLOT_V)) relHot[relHandle] = 1'b1;
  end

  assign freeVec = ~busy | relHot;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) kindMask[i] = reqData ? (i >= NUM_INST) : (i < NUM_INST);
  end

  assign candVec = freeVec & kindMask;

  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        pickFound = 1'b1;
        pickIdx   = i[HW-1:0];
      end
    end
  end

  assign trigBad = reqData ? !(reqTrig[TRIG_READ] || reqTrig[TRIG_WRITE]) : !reqTrig[TRIG_EXEC];
  assign rsvdBad = (reqCond[BE_LSB-1:VMODE_W] != '0) || (reqCond[COND_W-1:BE_LSB+NB] != '0);
  assign span    = reqAddrB - reqAddrA;

  always_comb begin
    alignBad = 1'b0;
    if (ALIGN8 && reqData) begin
      if (reqAddrA[2:0] != 3'd0) alignBad = 1'b1;
      if (reqAddrMode == AM_IN_RANGE &&
          (reqAddrB < reqAddrA || span > ADDR_W'(8))) alignBad = 1'b1;
    end
  end

  assign cfgBad = trigBad || rsvdBad || alignBad;
  assign accept = reqValid && !cfgBad && pickFound;

  always_comb begin
    strobe.load = accept;
    strobe.slot = SLOT_IW'(pickIdx);
    pickHot     = '0;
    if (accept) pickHot[pickIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= '0;
      rspValid   <= 1'b0;
      rspHandle  <= '0;
      rspNoSpace <= 1'b0;
      rspBadCfg  <= 1'b0;
    end else begin
      busy       <= (busy & ~relHot) | pickHot;
      rspValid   <= reqValid;
      rspHandle  <= accept ? pickIdx : '0;
      rspNoSpace <= reqValid && !cfgBad && !pickFound;
      rspBadCfg  <= reqValid && cfgBad;
    end
  end

  assign slotActive = busy;

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busy & ~$past(busy)));  // R1
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspNoSpace && !rspBadCfg) |-> busy[rspHandle]);  // R1
  AST_NOSPACE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    rspNoSpace |-> (busy == ($past(busy) & ~$past(relHot))));  // R2
  AST_BADCFG_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    rspBadCfg |-> (busy == ($past(busy) & ~$past(relHot))));  // R8

endmodule

// File: rtl/dbg_match_dp.sv
module dbg_match_dp
  import dbg_match_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int NUM_DATA = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  localparam int NSLOT   = NUM_INST + NUM_DATA,
  localparam int NB      = DATA_W / 8,
  localparam int HALF    = NB / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [NSLOT-1:0]   slotActive,
  input  logic               globalEn,
  input  logic               reqRd,
  input  logic               reqWr,
  input  logic [1:0]         reqAddrMode,
  input  logic [1:0]         reqVmode,
  input  logic [NB-1:0]      reqBe,
  input  logic [ADDR_W-1:0]  reqAddrA,
  input  logic [ADDR_W-1:0]  reqAddrB,
  input  logic [DATA_W-1:0]  reqValue,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [DATA_W-1:0]  accData,
  output logic [NSLOT-1:0]   hitVec,
  output logic               debugEvent
);

  logic [ADDR_W-1:0] cfgA    [NSLOT];
  logic [ADDR_W-1:0] cfgB    [NSLOT];
  addrMode_e         cfgMode [NSLOT];
  logic              cfgRd   [NUM_DATA];
  logic              cfgWr   [NUM_DATA];
  valMode_e          cfgVm   [NUM_DATA];
  logic [NB-1:0]     cfgBe   [NUM_DATA];
  logic [DATA_W-1:0] cfgVal  [NUM_DATA];
  logic [NSLOT-1:0]  hitNext;

  function automatic logic addrHit(input addrMode_e m, input logic [ADDR_W-1:0] x,
                                   input logic [ADDR_W-1:0] lo, input logic [ADDR_W-1:0] hi);
    case (m)
      AM_EXACT:     return x == lo;
      AM_IN_RANGE:  return (x >= lo) && (x <= hi);
      AM_OUT_RANGE: return (x < lo) || (x > hi);
      default:      return (x & hi) == (lo & hi);
    endcase
  endfunction

  function automatic logic valHit(input valMode_e vm, input logic [NB-1:0] be,
                                  input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] v);
    logic [NB-1:0] eq;
    logic loGrp, hiGrp;
    for (int b = 0; b < NB; b++) eq[b] = (d[8*b +: 8] == v[8*b +: 8]);
    loGrp = (be[HALF-1:0] != '0) && (&(eq[HALF-1:0] | ~be[HALF-1:0]));
    hiGrp = (be[NB-1:HALF] != '0) && (&(eq[NB-1:HALF] | ~be[NB-1:HALF]));
    case (vm)
      VC_NONE: return 1'b1;
      VC_ALL:  return &(eq | ~be);
      VC_ANY:  return (be == '0) || (|(eq & be));
      default: return (be == '0) || loGrp || hiGrp;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSLOT; i++) begin
        cfgA[i]    <= '0;
        cfgB[i]    <= '0;
        cfgMode[i] <= AM_EXACT;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (strobe.load && strobe.slot == SLOT_IW'(i)) begin
          cfgA[i]    <= reqAddrA;
          cfgB[i]    <= reqAddrB;
          cfgMode[i] <= addrMode_e'(reqAddrMode);
        end
      end
    end
  end

  // value side of a data slot loads on the same edge as its address side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < NUM_DATA; d++) begin
        cfgRd[d]  <= 1'b0;
        cfgWr[d]  <= 1'b0;
        cfgVm[d]  <= VC_NONE;
        cfgBe[d]  <= '0;
        cfgVal[d] <= '0;
      end
    end else begin
      for (int d = 0; d < NUM_DATA; d++) begin
        if (strobe.load && strobe.slot == SLOT_IW'(d + NUM_INST)) begin
          cfgRd[d]  <= reqRd;
          cfgWr[d]  <= reqWr;
          cfgVm[d]  <= valMode_e'(reqVmode);
          cfgBe[d]  <= reqBe;
          cfgVal[d] <= reqValue;
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    if (g < NUM_INST) begin : gInst
      assign hitNext[g] = globalEn && slotActive[g] && fetchValid &&
                          addrHit(cfgMode[g], fetchAddr, cfgA[g], cfgB[g]);
    end else begin : gData
      localparam int D = g - NUM_INST;
      logic dirOk;
      assign dirOk = accWrite ? cfgWr[D] : cfgRd[D];
      assign hitNext[g] = globalEn && slotActive[g] && accValid && dirOk &&
                          addrHit(cfgMode[g], accAddr, cfgA[g], cfgB[g]) &&
                          valHit(cfgVm[D], cfgBe[D], accData, cfgVal[D]);

      AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        (hitVec[g] && $past(accWrite)) |-> $past(cfgWr[D]));  // R8
      AST_DIR_READ: assert property (@(posedge clk) disable iff (!rstN)
        (hitVec[g] && !$past(accWrite)) |-> $past(cfgRd[D]));  // R8
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitVec     <= '0;
      debugEvent <= 1'b0;
    end else begin
      hitVec     <= hitNext;
      debugEvent <= |hitNext;
    end
  end

  AST_INST_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec[NUM_INST-1:0]) |-> $past(fetchValid));  // R11
  AST_DATA_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec[NSLOT-1:NUM_INST]) |-> $past(accValid));  // R11
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    debugEvent |-> $past(globalEn));  // R12
  AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec & ~$past(slotActive)) == '0);  // R12

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NUM_INST  = 4,
  parameter int NUM_DATA  = 2,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter bit ALIGN8    = 1'b0,
  localparam int NSLOT    = NUM_INST + NUM_DATA,
  localparam int HANDLE_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int NB       = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                globalEn,
  input  logic                reqValid,
  input  logic                reqData,
  input  logic [2:0]          reqTrig,
  input  logic [1:0]          reqAddrMode,
  input  logic [COND_W-1:0]   reqCond,
  input  logic [ADDR_W-1:0]   reqAddrA,
  input  logic [ADDR_W-1:0]   reqAddrB,
  input  logic [DATA_W-1:0]   reqValue,
  input  logic                relValid,
  input  logic [HANDLE_W-1:0] relHandle,
  output logic                rspValid,
  output logic [HANDLE_W-1:0] rspHandle,
  output logic                rspNoSpace,
  output logic                rspBadCfg,
  input  logic                fetchValid,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [DATA_W-1:0]   accData,
  output logic [NSLOT-1:0]    hitVec,
  output logic                debugEvent
);

  cfgStrobe_t       strobe;
  logic [NSLOT-1:0] slotActive;

  initial begin
    assert (HANDLE_W <= SLOT_IW && NB <= 8 && NB >= 2);
  end

  dbg_match_ctrl #(
    .NUM_INST(NUM_INST), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .NB(NB), .ALIGN8(ALIGN8)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqData(reqData), .reqTrig(reqTrig),
    .reqAddrMode(reqAddrMode), .reqCond(reqCond),
    .reqAddrA(reqAddrA), .reqAddrB(reqAddrB),
    .relValid(relValid), .relHandle(relHandle),
    .strobe(strobe), .slotActive(slotActive),
    .rspValid(rspValid), .rspHandle(rspHandle),
    .rspNoSpace(rspNoSpace), .rspBadCfg(rspBadCfg)
  );

  dbg_match_dp #(
    .NUM_INST(NUM_INST), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .slotActive(slotActive), .globalEn(globalEn),
    .reqRd(reqTrig[TRIG_READ]), .reqWr(reqTrig[TRIG_WRITE]),
    .reqAddrMode(reqAddrMode), .reqVmode(reqCond[VMODE_W-1:0]),
    .reqBe(reqCond[BE_LSB +: NB]),
    .reqAddrA(reqAddrA), .reqAddrB(reqAddrB), .reqValue(reqValue),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .accData(accData),
    .hitVec(hitVec), .debugEvent(debugEvent)
  );

endmodule

// File: tb/dbg_match_unit_bench.sv
module dbg_match_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b1;
  logic        reqValid = 1'b0, reqData = 1'b0;
  logic [2:0]  reqTrig = '0;
  logic [1:0]  reqAddrMode = '0;
  logic [31:0] reqCond = '0, reqAddrA = '0, reqAddrB = '0;
  logic [63:0] reqValue = '0;
  logic        relValid = 1'b0;
  logic [2:0]  relHandle = '0;
  logic        fetchValid = 1'b0, accValid = 1'b0, accWrite = 1'b0;
  logic [31:0] fetchAddr = '0, accAddr = '0;
  logic [63:0] accData = '0;
  logic        rspValid, rspNoSpace, rspBadCfg, debugEvent;
  logic [2:0]  rspHandle;
  logic [5:0]  hitVec;
  logic        aRspValid, aRspNoSpace, aRspBadCfg, aEvt;
  logic [2:0]  aRspHandle;
  logic [5:0]  aHit;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;
  logic [2:0] gotH;
  logic gotV, gotNs, gotBad, aV, aBad;

  always #5 clk = ~clk;

  dbg_match_unit u_dbg_match_unit (
    .clk, .rstN, .globalEn, .reqValid, .reqData, .reqTrig, .reqAddrMode, .reqCond,
    .reqAddrA, .reqAddrB, .reqValue, .relValid, .relHandle,
    .rspValid, .rspHandle, .rspNoSpace, .rspBadCfg,
    .fetchValid, .fetchAddr, .accValid, .accWrite, .accAddr, .accData,
    .hitVec, .debugEvent);

  dbg_match_unit #(.ALIGN8(1'b1)) u_dbg_match_unit_al (
    .clk, .rstN, .globalEn, .reqValid, .reqData, .reqTrig, .reqAddrMode, .reqCond,
    .reqAddrA, .reqAddrB, .reqValue, .relValid, .relHandle,
    .rspValid(aRspValid), .rspHandle(aRspHandle), .rspNoSpace(aRspNoSpace), .rspBadCfg(aRspBadCfg),
    .fetchValid, .fetchAddr, .accValid, .accWrite, .accAddr, .accData,
    .hitVec(aHit), .debugEvent(aEvt));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic isData, input logic [2:0] trig, input logic [1:0] mode,
                      input logic [31:0] cond, input logic [31:0] a, input logic [31:0] b,
                      input logic [63:0] val);
    @(negedge clk);
    reqValid = 1'b1; reqData = isData; reqTrig = trig; reqAddrMode = mode;
    reqCond = cond; reqAddrA = a; reqAddrB = b; reqValue = val;
    @(negedge clk);
    reqValid = 1'b0;
    gotV = rspValid; gotH = rspHandle; gotNs = rspNoSpace; gotBad = rspBadCfg;
    aV = aRspValid; aBad = aRspBadCfg;
  endtask

  task automatic rel(input logic [2:0] h);
    @(negedge clk);
    relValid = 1'b1; relHandle = h;
    @(negedge clk);
    relValid = 1'b0;
  endtask

  task automatic relAll();
    for (int h = 0; h < 6; h++) rel(3'(h));
  endtask

  task automatic fetch(input logic [31:0] x);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = x;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [31:0] x, input logic [63:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAddr = x; accData = d;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  function automatic logic expAddr(input logic [1:0] m, input logic [31:0] x,
                                   input logic [31:0] a, input logic [31:0] b);
    case (m)
      2'd0: return x == a;
      2'd1: return (x >= a) && (x <= b);
      2'd2: return (x < a) || (x > b);
      default: return (x & b) == (a & b);
    endcase
  endfunction

  // m: which bytes of the access data equal the programmed value bytes
  function automatic logic expVal(input logic [1:0] vm, input logic [7:0] be, input logic [7:0] m);
    logic lo, hi;
    lo = (be[3:0] != 0) && ((m[3:0] & be[3:0]) == be[3:0]);
    hi = (be[7:4] != 0) && ((m[7:4] & be[7:4]) == be[7:4]);
    case (vm)
      2'd0: return 1'b1;
      2'd1: return (m & be) == be;
      2'd2: return (be == 0) || ((m & be) != 0);
      default: return (be == 0) || lo || hi;
    endcase
  endfunction

  function automatic logic [63:0] mkData(input logic [63:0] v, input logic [7:0] m);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) d[8*b +: 8] = m[b] ? v[8*b +: 8] : ~v[8*b +: 8];
    return d;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  localparam logic [63:0] VAL = 64'h8877_6655_4433_2211;

  initial begin
    logic [7:0] beList [4];
    logic [1:0] amode [6];
    logic [31:0] aList [6];
    logic [31:0] bList [6];
    logic e;
    beList = '{8'hFF, 8'h0F, 8'h81, 8'h00};
    amode = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3};
    aList = '{32'd12, 32'd5, 32'd20, 32'd5, 32'd20, 32'h14};
    bList = '{32'd0, 32'd20, 32'd5, 32'd20, 32'd5, 32'h1C};

    repeat (3) @(negedge clk);
    chk("R12 reset hitVec", 64'(hitVec), 0);
    chk("R12 reset event", 64'(debugEvent), 0);
    chk("R12 reset rspValid", 64'(rspValid), 0);
    rstN = 1'b1;

    // R1 / R2: allocation order and exhaustion
    for (int i = 0; i < 4; i++) begin
      prog(1'b0, 3'd1, 2'd0, 0, 32'h100, 0, 0);
      chk("R1 inst handle", {gotV, gotNs, gotBad, gotH}, {3'b100, 3'(i)});
    end
    prog(1'b0, 3'd1, 2'd0, 0, 32'h100, 0, 0);
    chk("R2 inst no space", {gotV, gotNs, gotBad}, 3'b110);
    for (int i = 0; i < 2; i++) begin
      prog(1'b1, 3'd2, 2'd0, 0, 32'h100, 0, 0);
      chk("R1 data handle", {gotV, gotNs, gotBad, gotH}, {3'b100, 3'(4 + i)});
    end
    prog(1'b1, 3'd6, 2'd0, 0, 32'h100, 0, 0);
    chk("R2 data no space", {gotV, gotNs, gotBad}, 3'b110);

    // R3: release and request in the same cycle
    @(negedge clk);
    relValid = 1'b1; relHandle = 3'd2;
    reqValid = 1'b1; reqData = 1'b0; reqTrig = 3'd1; reqAddrMode = 2'd0; reqCond = 0;
    @(negedge clk);
    relValid = 1'b0; reqValid = 1'b0;
    chk("R3 same-cycle reuse", {rspValid, rspNoSpace, rspHandle}, {2'b10, 3'd2});
    relAll();
    prog(1'b0, 3'd1, 2'd0, 0, 32'h40, 0, 0);
    rel(3'd3);
    rel(3'd7);
    prog(1'b0, 3'd1, 2'd0, 0, 32'h40, 0, 0);
    chk("R3 free release ignored", 64'(gotH), 1);
    relAll();

    // R4..R7: address mode sweeps on instruction slot 0
    for (int k = 0; k < 6; k++) begin
      prog(1'b0, 3'd1, amode[k], 0, aList[k], bList[k], 0);
      for (int x = 0; x < 32; x++) begin
        fetch(32'(x));
        e = expAddr(amode[k], 32'(x), aList[k], bList[k]);
        case (amode[k])
          2'd0: chk("R4 exact", 64'(hitVec), e ? 64'd1 : 64'd0);
          2'd1: chk("R5 inclusive", 64'(hitVec), e ? 64'd1 : 64'd0);
          2'd2: chk("R6 exclusive", 64'(hitVec), e ? 64'd1 : 64'd0);
          default: chk("R7 mask", 64'(hitVec), e ? 64'd1 : 64'd0);
        endcase
      end
      rel(3'd0);
    end

    // R8: direction filtering and rejected descriptions
    for (int t = 1; t < 4; t++) begin
      prog(1'b1, 3'(t << 1), 2'd0, 0, 32'h80, 0, 0);
      access(1'b0, 32'h80, 0);
      chk("R8 read dir", 64'(hitVec), t[0] ? 64'h10 : 64'h0);
      access(1'b1, 32'h80, 0);
      chk("R8 write dir", 64'(hitVec), t[1] ? 64'h10 : 64'h0);
      rel(3'd4);
    end
    prog(1'b1, 3'd1, 2'd0, 0, 32'h80, 0, 0);
    chk("R8 data exec-only rejected", {gotBad, gotNs}, 2'b10);
    prog(1'b0, 3'd6, 2'd0, 0, 32'h80, 0, 0);
    chk("R8 inst without exec rejected", {gotBad, gotNs}, 2'b10);
    prog(1'b1, 3'd2, 2'd0, 32'h0000_0100, 32'h80, 0, 0);
    chk("R8 reserved cond bit rejected", {gotBad, gotNs}, 2'b10);
    access(1'b0, 32'h80, 0);
    chk("R8 rejected not loaded", 64'(hitVec), 0);

    // R9 / R10: value condition sweeps on data slot 4
    for (int vm = 0; vm < 4; vm++) begin
      for (int bi = 0; bi < 4; bi++) begin
        prog(1'b1, 3'd6, 2'd0, {8'h0, beList[bi], 14'h0, 2'(vm)}, 32'h200, 0, VAL);
        for (int m = 0; m < 256; m++) begin
          access(m[0], 32'h200, mkData(VAL, 8'(m)));
          e = expVal(2'(vm), beList[bi], 8'(m));
          if (vm < 2) chk("R9 value cond", 64'(hitVec), e ? 64'h10 : 64'h0);
          else chk("R10 value cond", 64'(hitVec), e ? 64'h10 : 64'h0);
        end
        rel(3'd4);
      end
    end

    // R11: fetch and data hits in the same cycle
    prog(1'b0, 3'd1, 2'd0, 0, 32'h300, 0, 0);
    prog(1'b1, 3'd2, 2'd1, 0, 32'h400, 32'h40F, 0);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 32'h300;
    accValid = 1'b1; accWrite = 1'b0; accAddr = 32'h408; accData = 0;
    #1;
    chk("R11 no same-cycle hit", {debugEvent, hitVec}, 0);
    @(negedge clk);
    fetchValid = 1'b0; accValid = 1'b0;
    chk("R11 joint hit", {debugEvent, hitVec}, {1'b1, 6'h11});
    @(negedge clk);
    chk("R11 pulse ends", {debugEvent, hitVec}, 0);

    // R12: global enable
    globalEn = 1'b0;
    fetch(32'h300);
    chk("R12 global off", {debugEvent, hitVec}, 0);
    globalEn = 1'b1;
    fetch(32'h300);
    chk("R12 global on", {debugEvent, hitVec}, {1'b1, 6'h01});
    relAll();

    // R13: alignment option on the second instance
    prog(1'b1, 3'd2, 2'd0, 0, 32'h11, 0, 0);
    chk("R13 misaligned rejected", {aV, aBad}, 2'b11);
    chk("R13 no option accepts", {gotV, gotBad}, 2'b10);
    relAll();
    prog(1'b1, 3'd2, 2'd0, 0, 32'h10, 0, 0);
    chk("R13 aligned accepted", {aV, aBad}, 2'b10);
    relAll();
    prog(1'b1, 3'd2, 2'd1, 0, 32'h10, 32'h18, 0);
    chk("R13 span 8 accepted", {aV, aBad}, 2'b10);
    relAll();
    prog(1'b1, 3'd2, 2'd1, 0, 32'h10, 32'h19, 0);
    chk("R13 span 9 rejected", {aV, aBad}, 2'b11);
    relAll();
    prog(1'b1, 3'd2, 2'd1, 0, 32'h18, 32'h10, 0);
    chk("R13 reversed rejected", {aV, aBad}, 2'b11);
    relAll();

    finishRun();
  end

endmodule